// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Status

This block is a first-in/first-out buffer of 512 words, each 9 bits wide. Words go in through a write strobe and come out through a read strobe. Both strobes act on internal circular pointers, so no address is ever given. All 9 bits are plain data, and the top bit may carry parity or a control mark if the user wants. A write and a read may be accepted in the same clock cycle.

Three status outputs report the fill level: empty, full, and a shared output that shows half-full when the mode input selects the stand-alone arrangement. An active-low retransmit input moves the read pointer back to the first word written since reset, so the stored stream can be read again. This only works while no more than 512 words have been written since reset. Cascading several buffers, tri-state outputs and power-down are not part of this block.

Top module: `fifo_rt`

## Requirements
- R1: Words come out in the order they were written, with all 9 bits preserved.
- R2: Read data is registered. It shows the word on `rd_data` in the cycle after an accepted read. Without an accepted read, `rd_data` holds its value.
- R3: `empty` is 1 exactly when the stored count is 0, and `full` is 1 exactly when it is 512. Both follow an accepted operation in the next cycle.
- R4: A write strobe while `full` is 1 is ignored. The stored contents and the count do not change.
- R5: A read strobe while `empty` is 1 is ignored. The count and `rd_data` do not change.
- R6: A write and a read accepted in the same cycle both take effect, and the count stays the same.
- R7: When `rt_n` is 0 at a clock edge, the read pointer returns to the first word written since reset. The count becomes the number of words written since reset, plus any write accepted in that same cycle. A read strobe in that cycle is ignored.
- R8: `hf_xo` is 1 when `hf_mode` is 1 and the count is 257 or more. It is 0 whenever `hf_mode` is 0.
- R9: While `rst_n` is 0, `empty` is 1, `full` is 0, `hf_xo` is 0, `rd_data` is 0 and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 9 | Registered read word |
| rt_n | input | 1 | Active-low retransmit |
| hf_mode | input | 1 | 1: shared status output shows half-full |
| empty | output | 1 | No words stored |
| full | output | 1 | 512 words stored |
| hf_xo | output | 1 | Half-full when `hf_mode` is 1, else 0 |

## Verification
The bench changes inputs on the falling edge, so each operation is taken at the next rising edge. A read word appears on `rd_data`, and every flag shows its new value, after that edge. The bench compares all of them on the falling edge that follows, one full cycle after the stimulus. The driver task pushes each expected word into a queue at the moment it predicts the read will be accepted. The same step pops the queue one cycle later. Cycles with no accepted read instead check that `rd_data` has held its last value.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rt_n,
  input  logic             hf_mode,
  output logic             empty,
  output logic             full,
  output logic             hf_xo
);
  localparam int AW = $clog2(DEPTH);
  localparam int HALF_MARK = DEPTH / 2 + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr, count;
  logic wr_ok, rd_ok;

  assign count = wptr - rptr;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign hf_xo = hf_mode && (count >= (AW+1)'(HALF_MARK));

  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty && rt_n;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (!rt_n) rptr <= '0;
      else if (rd_ok) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr[AW-1:0]];
      end
    end
  end

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en |=> wptr == $past(wptr)); // R4
  AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && rt_n |=> rptr == $past(rptr) && $stable(rd_data)); // R5
  AST_RT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> rptr == '0); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R3
  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R2
endmodule

// File: tb/fifo_rt_tb.sv
module fifo_rt_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rt_n = 1, hf_mode = 1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic empty, full, hf_xo;

  int vectors = 0, miscompares = 0;
  logic [8:0] wl[$];
  logic [8:0] exp_q[$];
  int ridx = 0;
  logic [8:0] last_rd = '0;

  always #2.5 clk = ~clk;

  fifo_rt u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rt_n(rt_n), .hf_mode(hf_mode),
    .empty(empty), .full(full), .hf_xo(hf_xo));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic flags(input string req);
    int cnt = wl.size() - ridx;
    chk(empty == (cnt == 0), {req, "/R3 empty"}, empty, cnt == 0);
    chk(full == (cnt == 512), {req, "/R3 full"}, full, cnt == 512);
    chk(hf_xo == (hf_mode && cnt >= 257), {req, "/R8 hf"}, hf_xo, hf_mode && cnt >= 257);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; rt_n = 1;
    wl.delete(); exp_q.delete(); ridx = 0; last_rd = '0;
    repeat (2) @(negedge clk);
    chk(empty == 1 && full == 0 && hf_xo == 0, "R9 flags", {empty, full, hf_xo}, 3'b100);
    chk(rd_data == 0, "R9 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic step(input logic w, input logic [8:0] wd, input logic r,
                      input logic rt, input string req, input bit do_flags = 1);
    int cnt = wl.size() - ridx;
    bit wacc = w && cnt < 512;
    bit racc = r && rt && cnt > 0;
    wr_en = w; wr_data = wd; rd_en = r; rt_n = rt;
    if (racc) begin exp_q.push_back(wl[ridx]); ridx++; end
    if (!rt) ridx = 0;
    if (wacc) wl.push_back(wd);
    @(negedge clk);
    wr_en = 0; rd_en = 0; rt_n = 1;
    if (racc) begin
      logic [8:0] e = exp_q.pop_front();
      chk(rd_data == e, {req, "/R1/R2 data"}, rd_data, e);
      last_rd = e;
    end else begin
      chk(rd_data == last_rd, {req, "/R2 hold"}, rd_data, last_rd);
    end
    if (do_flags) flags(req);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 9'(i * 37 + 256), 0, 1, "R1");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, "R1");
    step(0, 0, 1, 1, "R5 empty read");
    step(0, 0, 1, 1, "R5 empty read again");

    do_reset();
    for (int i = 0; i < 256; i++) step(1, 9'(i ^ 9'h155), 0, 1, "R8 fill", i >= 250);
    step(1, 9'h1AA, 0, 1, "R8 cross 257");
    hf_mode = 0; @(negedge clk);
    chk(hf_xo == 0, "R8 mode off", hf_xo, 0);
    hf_mode = 1; @(negedge clk);
    chk(hf_xo == 1, "R8 mode on", hf_xo, 1);
    for (int i = 257; i < 512; i++) step(1, 9'(i * 3), 0, 1, "R3 fill", i >= 510);
    step(1, 9'h0F0, 0, 1, "R4 write full");
    step(1, 9'h0F1, 1, 1, "R4 write full with read");
    step(0, 0, 1, 1, "R8 drop");
    for (int i = 0; i < 300; i++) step(0, 0, 1, 1, "R4 drain", i > 250);

    do_reset();
    for (int i = 0; i < 10; i++) step(1, 9'(i + 100), 0, 1, "R7 load");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, "R7 pre-read");
    step(1, 9'd200, 1, 0, "R7 rewind");
    chk(empty == 0, "R7 count after rewind", empty, 0);
    for (int i = 0; i < 11; i++) step(0, 0, 1, 1, "R7 reread");
    step(0, 0, 1, 1, "R7 empty after reread");

    do_reset();
    step(1, 9'h101, 0, 1, "R6 prime");
    for (int i = 0; i < 20; i++) step(1, 9'(i + 7), 1, 1, "R6 simultaneous");
    step(1, 9'h033, 1, 1, "R6 last");
    step(0, 0, 1, 1, "R6 drain");
    step(0, 0, 1, 1, "R6 drain2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule